// File: doc/BRIEF.md
# Rotating-Priority Rule Conflict Scheduler

This block decides, in every clock cycle, which of a set of guarded rules may fire. Each rule raises a ready line when its guard holds. A constant write map records which state registers each rule updates. Two rules that write the same register must not fire in the same cycle. The scheduler visits the rules in the current priority order. It keeps a running set of registers already claimed by rules that have fired. A ready rule fires when none of its registers is in that set, and it then adds its own registers to the set. As a result, every ready rule that does not collide with a higher-priority winner fires in the same cycle.

The priority order is a rotation with a single head rule. The head is the current state of a small state machine with one state per rule, HEAD_0 up to HEAD_(N-1). Reset forces HEAD_0. Every clock edge takes the transition ADVANCE from HEAD_k to HEAD_(k+1), and from the last state back to HEAD_0. The rule that had top priority in one cycle therefore has the lowest priority in the next. The fire vector is combinational from the ready lines and the head state, so a rule body can commit in the same cycle it is granted.

Top module: `rule_sched`

## Requirements
- R1: A rule whose ready input is low never has its fire output high, and it claims no register.
- R2: No two rules that fire in the same cycle write a common register.
- R3: A ready rule that is not fired shares at least one register with a rule that fires in that cycle. A lone ready rule always fires.
- R4: When the head rule is ready, it fires.
- R5: The rules are visited in the order head, head+1, and so on, wrapping modulo NUM_RULES. A ready rule is blocked only by a rule earlier in that order that has fired and writes one of its registers.
- R6: Reset (rst_n low, asynchronous) puts the head at rule 0. Each rising clock edge out of reset advances the head by one, wrapping from NUM_RULES-1 to 0. So n edges after reset, the head is n mod NUM_RULES.
- R7: A rule held ready waits for at most NUM_RULES-1 consecutive cycles without firing.
- R8: When the write map gives every register at most one writer, fire equals ready in every cycle.
- R9: The fire output follows a change of the ready inputs within the same cycle, with no register on the path.
- R10: The write map is a NUM_RULES*NUM_REGS-bit parameter. Bit r*NUM_REGS+g set means rule r writes register g. The default map for 4 rules and 4 registers is 16'h8463:
  - rule 0 writes registers 0 and 1;
  - rule 1 writes registers 1 and 2;
  - rule 2 writes register 2;
  - rule 3 writes register 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the head advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the head to rule 0 |
| ready | input | NUM_RULES | Guard of each rule; bit r high means rule r wants to fire |
| fire | output | NUM_RULES | Grant of each rule in this cycle |

## Verification
The hardest case to reach from the ports is a chain of conflicts. In such a chain, a blocked rule in the middle releases a register that lets a lower-priority rule fire. This has to happen while the head sits at each of the rotation states. The default map chains rule 0 to rule 1 to rule 2, and the head moves every cycle. Random ready patterns run for hundreds of cycles, so every pattern meets every head position. A bench model tracks the head from the reset edge and computes the expected grants. A directed reset in the middle of the run checks that the head returns to rule 0, and held-ready windows check the wait bound. A second instance with a conflict-free map checks that fire passes ready straight through.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // True when no register column of the map has more than one writer.
    function automatic bit map_is_disjoint(input int rules, input int regs,
                                           input logic [63:0] wmap);
        for (int g = 0; g < regs; g++) begin
            int writers;
            writers = 0;
            for (int r = 0; r < rules; r++)
                if (wmap[r*regs + g]) writers++;
            if (writers > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/sched_rotor.sv
module sched_rotor #(
    parameter int NUM_RULES = 4,
    localparam int PW = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] head
);
    localparam logic [PW-1:0] LAST = PW'(NUM_RULES - 1);

    logic [PW-1:0] head_q;
    logic          past_ok;

    // State register: HEAD_k takes ADVANCE on every edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) head_q <= '0;
        else        head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign head = head_q;

    // R6: the head steps by one and wraps after the last rule
    p_head_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (($past(head_q) == LAST) ? (head_q == '0)
                                             : (head_q == $past(head_q) + 1'b1)));

    p_head_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        head_q <= LAST);
endmodule

// File: rtl/sched_claim_walk.sv
module sched_claim_walk #(
    parameter int NUM_RULES = 4,
    parameter int NUM_REGS  = 4,
    parameter logic [NUM_RULES*NUM_REGS-1:0] WRITE_MAP = '0,
    localparam int PW = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic [NUM_RULES-1:0] ready,
    input  logic [PW-1:0]        head,
    output logic [NUM_RULES-1:0] fire
);
    logic [NUM_REGS-1:0] claimed;
    logic [NUM_REGS-1:0] row;
    logic [PW:0]         idx;

    // Walk the rules in priority order, accumulating register claims.
    always_comb begin
        claimed = '0;
        fire    = '0;
        row     = '0;
        idx     = '0;
        for (int k = 0; k < NUM_RULES; k++) begin
            idx = {1'b0, head} + (PW+1)'(k);
            if (idx >= (PW+1)'(NUM_RULES)) idx = idx - (PW+1)'(NUM_RULES);
            row = WRITE_MAP[int'(idx)*NUM_REGS +: NUM_REGS];
            if (ready[idx[PW-1:0]] && ((row & claimed) == '0)) begin
                fire[idx[PW-1:0]] = 1'b1;
                claimed           = claimed | row;
            end
        end
    end
endmodule

// File: rtl/rule_sched.sv
module rule_sched #(
    parameter int NUM_RULES = 4,
    parameter int NUM_REGS  = 4,
    parameter logic [NUM_RULES*NUM_REGS-1:0] WRITE_MAP = 16'h8463,
    localparam int PW = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RULES-1:0] ready,
    output logic [NUM_RULES-1:0] fire
);
    localparam bit NO_SHARE =
        sched_pkg::map_is_disjoint(NUM_RULES, NUM_REGS, 64'(WRITE_MAP));

    logic [PW-1:0] head;

    sched_rotor #(.NUM_RULES(NUM_RULES)) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .head  (head)
    );

    sched_claim_walk #(
        .NUM_RULES (NUM_RULES),
        .NUM_REGS  (NUM_REGS),
        .WRITE_MAP (WRITE_MAP)
    ) u_walk (
        .ready (ready),
        .head  (head),
        .fire  (fire)
    );

    // Union of registers written by the fired rules, built from the outputs.
    logic [NUM_REGS-1:0] fired_regs;
    always_comb begin
        fired_regs = '0;
        for (int r = 0; r < NUM_RULES; r++)
            if (fire[r]) fired_regs = fired_regs | WRITE_MAP[r*NUM_REGS +: NUM_REGS];
    end

    // R1: a rule with its guard low is never granted
    p_guard_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire & ~ready) == '0);

    // R4: the head rule wins when it is ready
    p_head_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready[head] |-> fire[head]);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_col
            logic [NUM_RULES-1:0] writers;
            for (genvar r = 0; r < NUM_RULES; r++) begin : g_bit
                assign writers[r] = WRITE_MAP[r*NUM_REGS + g];
            end
            // R2: at most one granted writer per register
            p_one_writer_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(fire & writers) <= 1);
        end

        for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
            logic [PW:0] wait_cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                   wait_cnt <= '0;
                else if (ready[r] && !fire[r]) wait_cnt <= wait_cnt + 1'b1;
                else                          wait_cnt <= '0;
            end
            // R3: a ready loser collides with some granted rule
            p_blocked_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[r] && !fire[r]) |->
                    ((WRITE_MAP[r*NUM_REGS +: NUM_REGS] & fired_regs) != '0));
            // R7: bounded wait for a rule held ready
            p_bounded_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
                wait_cnt <= (PW+1)'(NUM_RULES - 1));
        end

        if (NO_SHARE) begin : g_free
            // R8: a conflict-free map grants every ready rule
            p_free_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
                fire == ready);
        end
    endgenerate
endmodule

// File: tb/tb_rule_sched.sv
`timescale 1ns/1ps
module tb_rule_sched;
    localparam int NR = 4;
    localparam int NG = 4;
    localparam logic [15:0] MAP_A = 16'h8463;
    localparam logic [15:0] MAP_B = 16'h8421;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NR-1:0] ready_a = '0, ready_b = '0;
    logic [NR-1:0] fire_a, fire_b;
    int checks = 0, failures = 0, mptr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rule_sched #(.NUM_RULES(NR), .NUM_REGS(NG), .WRITE_MAP(MAP_A)) dut (
        .clk(clk), .rst_n(rst_n), .ready(ready_a), .fire(fire_a));
    rule_sched #(.NUM_RULES(NR), .NUM_REGS(NG), .WRITE_MAP(MAP_B)) dut_free (
        .clk(clk), .rst_n(rst_n), .ready(ready_b), .fire(fire_b));

    // Head model from R6
    always @(posedge clk or negedge rst_n)
        if (!rst_n) mptr <= 0;
        else        mptr <= (mptr + 1) % NR;

    // Expected grants from R5 and R10
    function automatic logic [NR-1:0] model(input logic [NR-1:0] rdy, input int hd,
                                            input logic [15:0] wmap);
        logic [NG-1:0] taken = '0;
        logic [NR-1:0] g = '0;
        for (int k = 0; k < NR; k++) begin
            int r = (hd + k) % NR;
            logic [NG-1:0] w = wmap[r*NG +: NG];
            if (rdy[r] && ((w & taken) == '0)) begin
                g[r] = 1'b1;
                taken = taken | w;
            end
        end
        return g;
    endfunction

    function automatic bit disjoint(input logic [NR-1:0] g, input logic [15:0] wmap);
        logic [NG-1:0] acc = '0;
        for (int r = 0; r < NR; r++)
            if (g[r]) begin
                if ((acc & wmap[r*NG +: NG]) != '0) return 1'b0;
                acc = acc | wmap[r*NG +: NG];
            end
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b head=%0d", req, act, exp, mptr);
        end
    endtask

    task automatic drive(input logic [NR-1:0] a, input logic [NR-1:0] b);
        @(negedge clk);
        ready_a = a;
        ready_b = b;
        #1;
    endtask

    initial begin
        logic [NR-1:0] seen;
        logic [NR-1:0] a, b;
        void'($urandom(32'd7));
        repeat (2) @(negedge clk);
        // R6 reset state: head at rule 0, all ready -> rules 0,2,3
        ready_a = 4'hF; #1;
        chk("R6 reset head", fire_a, 4'hD);
        ready_a = 4'h0; #1;
        chk("R1 idle in reset", fire_a, 4'h0);
        @(negedge clk); rst_n = 1'b1;

        for (int k = 0; k < NR; k++) begin
            drive(4'h0, 4'h0);
            chk("R1 no guard no grant", fire_a, 4'h0);
            drive(4'(1 << k), 4'h0);
            chk("R3 lone rule fires", fire_a, 4'(1 << k));
        end

        for (int k = 0; k < 2*NR; k++) begin
            drive(4'hF, 4'hF);
            chk("R4 head fires", {3'b0, fire_a[mptr]}, 4'h1);
            chk("R5 all ready", fire_a, model(4'hF, mptr, MAP_A));
        end

        seen = '0;
        for (int k = 0; k < NR; k++) begin
            drive(4'hF, 4'h0);
            seen = seen | fire_a;
        end
        chk("R7 every rule served", seen, 4'hF);

        // R9 same-cycle response
        @(negedge clk);
        ready_a = 4'h2; #1;
        chk("R9 follow ready", fire_a, 4'h2);
        ready_a = 4'h4; #1;
        chk("R9 follow change", fire_a, 4'h4);

        for (int n = 0; n < 400; n++) begin
            a = 4'($urandom % 16);
            b = 4'($urandom % 16);
            drive(a, b);
            chk("R5 grant pattern", fire_a, model(a, mptr, MAP_A));
            chk("R2 disjoint writes", {3'b0, disjoint(fire_a, MAP_A)}, 4'h1);
            chk("R8 free map passes", fire_b, b);
            if (n == 200) begin
                @(negedge clk);
                rst_n = 1'b0; ready_a = 4'hF; #1;
                chk("R6 reset mid-run", fire_a, 4'hD);
                @(negedge clk); rst_n = 1'b1;
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule